// File: doc/BRIEF.md
# Equal-pair serial bit detector

This block watches a single serial bit stream, taking one sample of `w_in` on every rising clock edge. It raises `z_out` when the newest two samples are the same: two zeros in a row or two ones in a row. A sample history that crosses a reset never counts. The first sample taken after reset has nothing earlier to pair with.

A build-time parameter picks one of three internal forms.

- The registered form is a five-state machine. Its output is a state bit. The idle state, which only reset can reach, is kept apart from the four working states by the top state bit.
- The look-ahead form uses two flip-flops. It compares the live input against the stored previous sample, so its answer appears one clock earlier.
- The split form runs a ones-pair detector and a zeros-pair detector side by side and ORs their outputs. It gives the same cycle timing as the registered form.

Top module: `pair_match_det`

## Requirements
- R1: While `rst_n` is low, `z_out` is 0 in every form. Samples taken before a reset never pair with samples taken after it.
- R2: Parameter `ARCH` selects the form: value 0 is the registered form, 1 is the look-ahead form, 2 is the split form.
- R3: In the registered form, once at least two samples have been taken since reset, `z_out` after each clock edge is 1 exactly when the two most recent samples are equal.
- R4: In the registered form, `z_out` stays 0 until the second sample after reset has been taken.
- R5: In the look-ahead form, once at least one sample has been taken since reset, `z_out` is 1 exactly when the present `w_in` equals the most recent sample. It follows `w_in` with no register in between.
- R6: In the look-ahead form, `z_out` is 0 before the first sample after reset, whatever `w_in` is.
- R7: The registered form's `z_out` in a given cycle equals the look-ahead form's `z_out` in the previous cycle of the same post-reset stream.
- R8: The split form produces the same `z_out` as the registered form in every cycle.
- R9: During a run of equal bits, `z_out` stays 1 from the run's second sample until the run ends. A strictly alternating stream keeps `z_out` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| w_in | input | 1 | Serial data bit, sampled each rising edge |
| z_out | output | 1 | Equal-pair indication |

## Verification
The bench builds the block three times, once for each value of `ARCH` (0, 1 and 2), and drives all three from the same stream. This puts the one-clock lag between the registered and look-ahead forms within reach of a direct comparison. It also lets the split form be compared with the registered form cycle for cycle. Long runs, alternating stretches, a pseudo-random stretch and a reset in mid-stream are all seen by all three forms.

// File: rtl/pmd_pkg.sv
`timescale 1ns/1ps
package pmd_pkg;

  // Form selector for the detector
  typedef enum logic [1:0] {
    ARCH_MOORE = 2'd0,
    ARCH_MEALY = 2'd1,
    ARCH_SPLIT = 2'd2
  } arch_e;

  // Registered form state vector {live, last, hit}
  localparam int unsigned MST_W    = 3;
  localparam int unsigned MST_LIVE = 2;
  localparam int unsigned MST_LAST = 1;
  localparam int unsigned MST_HIT  = 0;

  localparam logic [MST_W-1:0] MST_IDLE = 3'b000;

endpackage

// File: rtl/pmd_moore.sv
`timescale 1ns/1ps
// Registered five-state detector.
// Idle is 000 and only reset reaches it.
// Working states all have the live bit set:
// 100 one zero, 101 two or more zeros, 110 one one, 111 two or more ones.
module pmd_moore
  import pmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic w,
  output logic z
);

  logic [MST_W-1:0] st_q;
  logic [MST_W-1:0] st_d;

  always_comb begin
    st_d[MST_LIVE] = 1'b1;
    st_d[MST_LAST] = w;
    st_d[MST_HIT]  = (w & st_q[MST_LAST]) |
                     (~w & st_q[MST_LIVE] & ~st_q[MST_LAST]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= MST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign z = st_q[MST_HIT];

endmodule

// File: rtl/pmd_mealy.sv
`timescale 1ns/1ps
// Look-ahead detector: one seen flag and the previous sample.
module pmd_mealy (
  input  logic clk,
  input  logic rst_n,
  input  logic w,
  output logic z
);

  logic seen_q, seen_d;
  logic last_q, last_d;

  always_comb begin
    seen_d = 1'b1;
    last_d = w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      last_q <= last_d;
    end
  end

  // last_q is cleared by reset, so the ones term needs no seen qualifier
  assign z = (~w & seen_q & ~last_q) | (w & last_q);

endmodule

// File: rtl/pmd_split.sv
`timescale 1ns/1ps
// Two independent pair detectors, one per polarity, ORed together.
module pmd_split (
  input  logic clk,
  input  logic rst_n,
  input  logic w,
  output logic z
);

  logic one_q,  one_d;   // last sample was 1
  logic ones_q, ones_d;  // last two samples were 1
  logic zer_q,  zer_d;   // last sample was 0
  logic zers_q, zers_d;  // last two samples were 0

  always_comb begin
    one_d  = w;
    ones_d = w & one_q;
    zer_d  = ~w;
    zers_d = ~w & zer_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      one_q  <= 1'b0;
      ones_q <= 1'b0;
      zer_q  <= 1'b0;
      zers_q <= 1'b0;
    end else begin
      one_q  <= one_d;
      ones_q <= ones_d;
      zer_q  <= zer_d;
      zers_q <= zers_d;
    end
  end

  assign z = ones_q | zers_q;

endmodule

// File: rtl/pair_match_det.sv
`timescale 1ns/1ps
module pair_match_det #(
  parameter pmd_pkg::arch_e ARCH = pmd_pkg::ARCH_MOORE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic w_in,
  output logic z_out
);

  generate
    if (ARCH == pmd_pkg::ARCH_MEALY) begin : g_mealy
      pmd_mealy u_core (.clk(clk), .rst_n(rst_n), .w(w_in), .z(z_out));
    end else if (ARCH == pmd_pkg::ARCH_SPLIT) begin : g_split
      pmd_split u_core (.clk(clk), .rst_n(rst_n), .w(w_in), .z(z_out));
    end else begin : g_moore
      pmd_moore u_core (.clk(clk), .rst_n(rst_n), .w(w_in), .z(z_out));
    end
  endgenerate

endmodule

// File: rtl/pmd_checker.sv
`timescale 1ns/1ps
module pmd_checker #(
  parameter pmd_pkg::arch_e ARCH = pmd_pkg::ARCH_MOORE
) (
  input logic clk,
  input logic rst_n,
  input logic w_in,
  input logic z_out
);

  logic [1:0] cnt_q;
  logic       h1_q;
  logic       h0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      h1_q  <= 1'b0;
      h0_q  <= 1'b0;
    end else begin
      if (cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
      h1_q <= w_in;
      h0_q <= h1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (z_out == 1'b0);
    end
  end

  generate
    if (ARCH == pmd_pkg::ARCH_MEALY) begin : g_mealy
      a_r6_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 2'd0) |-> !z_out);
      a_r5_live_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != 2'd0) |-> (z_out == (w_in == h1_q)));
    end else begin : g_reg
      // R8: the split form is held to the same registered timing
      a_r4_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != 2'd2) |-> !z_out);
      a_r3_pair_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 2'd2) |-> (z_out == (h1_q == h0_q)));
      a_r9_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (z_out && (w_in == h1_q)) |=> z_out);
    end
  endgenerate

endmodule

bind pair_match_det pmd_checker #(.ARCH(ARCH)) i_pmd_checker (
  .clk(clk), .rst_n(rst_n), .w_in(w_in), .z_out(z_out)
);

// File: tb/test_pair_match_det.sv
`timescale 1ns/1ps
module test_pair_match_det;

  logic clk = 1'b0;
  logic rst_n;
  logic w;
  logic z_moore, z_mealy, z_split;

  always #2.5 clk = ~clk;

  pair_match_det #(.ARCH(pmd_pkg::ARCH_MOORE)) i_pair_match_det (
    .clk(clk), .rst_n(rst_n), .w_in(w), .z_out(z_moore));
  pair_match_det #(.ARCH(pmd_pkg::ARCH_MEALY)) i_pair_match_det_mealy (
    .clk(clk), .rst_n(rst_n), .w_in(w), .z_out(z_mealy));
  pair_match_det #(.ARCH(pmd_pkg::ARCH_SPLIT)) i_pair_match_det_split (
    .clk(clk), .rst_n(rst_n), .w_in(w), .z_out(z_split));

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // scoreboard queues, filled by the driver
  bit    q_moore[$];
  bit    q_mealy[$];
  int    q_idx[$];
  string q_tag[$];

  // bench-side sample history
  int    nsmp;
  bit    h1, h0;
  string phase_tag = "R3";
  bit    prev_mealy;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input bit b);
    @(negedge clk);
    w = b;
    q_mealy.push_back((nsmp >= 1) && (b == h1));
    q_moore.push_back((nsmp >= 2) && (h1 == h0));
    q_idx.push_back(nsmp);
    q_tag.push_back(phase_tag);
    h0 = h1;
    h1 = b;
    nsmp++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    w = 1'b1;
    #1;
    chk(z_moore, 1'b0, "R1 moore in reset");
    chk(z_mealy, 1'b0, "R1 mealy in reset");
    chk(z_split, 1'b0, "R1 split in reset");
    @(negedge clk);
    w = 1'b0;
    #1;
    chk(z_moore, 1'b0, "R1 moore held");
    chk(z_mealy, 1'b0, "R1 mealy held");
    chk(z_split, 1'b0, "R1 split held");
    @(posedge clk);
    #1 rst_n = 1'b1;
    nsmp = 0;
    h1 = 1'b0;
    h0 = 1'b0;
  endtask

  // monitor: pops one expectation per cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_mealy.size() > 0) begin
        bit    em, er;
        int    k;
        string tg;
        em = q_mealy.pop_front();
        er = q_moore.pop_front();
        k  = q_idx.pop_front();
        tg = q_tag.pop_front();
        if (k < 1) chk(z_mealy, em, "R6 mealy before first sample");
        else       chk(z_mealy, em, "R2,R5 mealy live compare");
        if (k < 2) chk(z_moore, er, "R4 moore before second sample");
        else       chk(z_moore, er, {tg, " moore pair"});
        chk(z_split, er, "R8 split vs registered");
        if (k >= 1) chk(z_moore, prev_mealy, "R7 registered lags look-ahead");
        prev_mealy = z_mealy;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit [7:0] lfsr;
    rst_n = 1'b0;
    w = 1'b0;
    nsmp = 0;
    h1 = 1'b0;
    h0 = 1'b0;
    prev_mealy = 1'b0;
    #1;
    chk(z_moore, 1'b0, "R1 moore reset state");
    chk(z_mealy, 1'b0, "R1 mealy reset state");
    chk(z_split, 1'b0, "R1 split reset state");
    do_reset();

    phase_tag = "R9";
    for (int i = 0; i < 6; i++) send(1'b1);
    for (int i = 0; i < 6; i++) send(1'b0);
    for (int i = 0; i < 10; i++) send(i[0]);

    phase_tag = "R3";
    lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      send(lfsr[0]);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    // history before a reset must not pair with what follows
    send(1'b1);
    send(1'b1);
    @(negedge clk);
    #2;
    do_reset();
    send(1'b1);
    send(1'b1);
    send(1'b0);
    send(1'b0);
    send(1'b1);
    @(negedge clk);
    #2;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule